// File: doc/BRIEF.md
# Accumulator Byte Adder Execute Unit

This block is the add stage of a small 8-bit accumulator processor. It takes a stream of opcode and immediate bytes through a valid/ready handshake, decodes the plain-add and add-with-carry groups, and writes the byte sum back into the accumulator together with a complete new set of four flags: zero, subtract, half-carry and carry. The second operand comes from one of six general byte registers, from a byte that follows the opcode, or from memory at the address held in the high/low register pair. For the memory case the unit raises a read request and stalls until the read data is marked valid.

The general registers, the accumulator and the flag byte are loaded from the surrounding core through a narrow load port. The current accumulator and flag byte are visible on the outputs. Any opcode outside the supported map gives a one-cycle illegal pulse and changes no state.

Top module: `accadd_unit`

## Requirements
- R1: After reset the accumulator, all six general registers and the flag byte are zero. `in_ready` is 1, and `mem_req`, `done_o` and `illegal_o` are 0.
- R2: Load port selector codes are 0..5 for the general registers (0 B, 1 C, 2 D, 3 E, 4 H, 5 L), 6 for the flag byte and 7 for the accumulator. A load takes effect at the clock edge where `ld_en` is 1.
- R3: Opcodes 0x80..0x85 add register B..L (selected by opcode bits 2:0) to the accumulator. The sum appears on `acc_o`, and `done_o` pulses for one cycle in the cycle after the opcode is accepted.
- R4: Opcodes 0x88..0x8D add register B..L (selected by opcode bits 2:0) plus the carry flag as it stands at acceptance.
- R5: Opcode 0xC6 takes the next accepted byte as the operand. `in_ready` stays 1 between the two bytes. No result appears until the second byte, and the result and `done_o` show in the cycle after that byte is accepted.
- R6: Opcode 0x86 drives `mem_req`=1 with `mem_addr`={H,L} from the cycle after acceptance. The request is held, `in_ready` is 0 and input bytes are ignored until `mem_rvalid`. The sum of the accumulator and `mem_rdata` appears in the cycle after `mem_rvalid`.
- R7: The zero flag is set exactly when the 8-bit result is zero. For add-with-carry the carry-in takes part in the sum.
- R8: Every add clears the subtract flag.
- R9: The half-carry flag is set when the low-nibble sum, carry-in included, exceeds 0xF.
- R10: The carry flag is set when the 9-bit sum, carry-in included, exceeds 0xFF.
- R11: The flag byte holds zero, subtract, half-carry and carry in bits 7, 6, 5 and 4, and bits 3..0 always read 0, including after a load.
- R12: Any other opcode pulses `illegal_o` for one cycle in the cycle after acceptance, leaves the accumulator and flags unchanged, and keeps `in_ready` at 1.
- R13: When a load and a write-back fall in the same cycle, the write-back wins for the accumulator and the flag byte, and a load to a general register still applies. The instruction uses the register value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Opcode or immediate byte |
| in_valid | input | 1 | `in_byte` is valid |
| in_ready | output | 1 | Unit accepts a byte this cycle |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register selector for a load |
| ld_data | input | 8 | Load data |
| mem_req | output | 1 | Memory read request, held until data returns |
| mem_addr | output | 16 | Read address {H,L} |
| mem_rdata | input | 8 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| acc_o | output | 8 | Accumulator |
| flag_o | output | 8 | Flag byte |
| done_o | output | 1 | One-cycle pulse after a write-back |
| illegal_o | output | 1 | One-cycle pulse after an unsupported opcode |

## Verification
A register load from the core and an instruction write-back can land on the same clock edge, and the two may even target the same storage. The bench provokes this by driving `ld_en` in the cycle an add opcode is accepted. In one case the load targets the accumulator, and the bench expects the computed sum rather than the loaded byte. In another case the load targets the source register, and the bench expects the sum built from the old value. A following add from that register then exposes the newly loaded value at the accumulator.

// File: rtl/accadd_pkg.sv
package accadd_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int NREG   = 8;
  localparam int SEL_W  = $clog2(NREG);
  localparam int ADDR_W = 2 * BYTE_W;

  localparam logic [SEL_W-1:0] SEL_H = 3'd4;
  localparam logic [SEL_W-1:0] SEL_L = 3'd5;
  localparam logic [SEL_W-1:0] SEL_F = 3'd6;
  localparam logic [SEL_W-1:0] SEL_A = 3'd7;

  typedef enum logic [1:0] {OPK_REG, OPK_MEM, OPK_IMM, OPK_BAD} opk_e;

  typedef struct packed {
    opk_e             kind;
    logic [SEL_W-1:0] src;
    logic             with_c;
  } dec_t;

  typedef struct packed {
    logic [BYTE_W-1:0] sum;
    logic              z;
    logic              n;
    logic              h;
    logic              c;
  } alu_res_t;

  // Byte add with carry-in, nibble half-carry and 9th-bit carry.
  function automatic alu_res_t add_bytes(input logic [BYTE_W-1:0] a,
                                         input logic [BYTE_W-1:0] b,
                                         input logic ci);
    alu_res_t        r;
    logic [BYTE_W:0] wide;
    logic [NIB_W:0]  low;
    wide  = {1'b0, a} + {1'b0, b} + {{BYTE_W{1'b0}}, ci};
    low   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
    r.sum = wide[BYTE_W-1:0];
    r.z   = (wide[BYTE_W-1:0] == '0);
    r.n   = 1'b0;
    r.h   = low[NIB_W];
    r.c   = wide[BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/accadd_decode.sv
module accadd_decode
  import accadd_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output dec_t              dec
);
  always_comb begin
    dec.kind   = OPK_BAD;
    dec.src    = op[SEL_W-1:0];
    dec.with_c = 1'b0;
    if (op[7:4] == 4'h8 && op[2:0] <= 3'd5) begin
      dec.kind   = OPK_REG;
      dec.with_c = op[3];
    end else if (op == 8'h86) begin
      dec.kind = OPK_MEM;
    end else if (op == 8'hC6) begin
      dec.kind = OPK_IMM;
    end
  end
endmodule

// File: rtl/accadd_alu.sv
module accadd_alu
  import accadd_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              ci,
  output alu_res_t          res
);
  assign res = add_bytes(a, b, ci);
endmodule

// File: rtl/accadd_regs.sv
module accadd_regs
  import accadd_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_en,
  input  logic [SEL_W-1:0]            ld_sel,
  input  logic [BYTE_W-1:0]           ld_data,
  input  logic                        wb_en,
  input  logic [BYTE_W-1:0]           wb_acc,
  input  logic [3:0]                  wb_flags,
  output logic [NREG-1:0][BYTE_W-1:0] regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [SEL_W-1:0] ME = SEL_W'(i);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wb_en && ME == SEL_A) begin
        q <= wb_acc;
      end else if (wb_en && ME == SEL_F) begin
        q <= {wb_flags, 4'h0};
      end else if (ld_en && ld_sel == ME) begin
        q <= (ME == SEL_F) ? {ld_data[7:4], 4'h0} : ld_data;
      end
    end
    assign regs_o[i] = q;
  end

  AST_F_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[SEL_F][3:0] == 4'h0); // R11
endmodule

// File: rtl/accadd_unit.sv
module accadd_unit
  import accadd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         in_byte,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               ld_en,
  input  logic [2:0]         ld_sel,
  input  logic [7:0]         ld_data,
  output logic               mem_req,
  output logic [15:0]        mem_addr,
  input  logic [7:0]         mem_rdata,
  input  logic               mem_rvalid,
  output logic [7:0]         acc_o,
  output logic [7:0]         flag_o,
  output logic               done_o,
  output logic               illegal_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_IMM, ST_MEM} st_e;

  st_e                         st_q, st_d;
  dec_t                        dec;
  alu_res_t                    res;
  logic [NREG-1:0][BYTE_W-1:0] regs;
  logic                        accept;
  logic                        wb_fire;
  logic                        ill_hit;
  logic [BYTE_W-1:0]           operand;
  logic                        carry_in;
  logic                        done_q, ill_q;

  accadd_decode u_dec (.op(in_byte), .dec(dec));

  accadd_alu u_alu (
    .a  (regs[SEL_A]),
    .b  (operand),
    .ci (carry_in),
    .res(res)
  );

  accadd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_data (ld_data),
    .wb_en   (wb_fire),
    .wb_acc  (res.sum),
    .wb_flags({res.z, res.n, res.h, res.c}),
    .regs_o  (regs)
  );

  assign in_ready = (st_q != ST_MEM);
  assign accept   = in_valid && in_ready;

  always_comb begin
    st_d     = st_q;
    wb_fire  = 1'b0;
    ill_hit  = 1'b0;
    operand  = in_byte;
    carry_in = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        unique case (dec.kind)
          OPK_REG: begin
            wb_fire  = 1'b1;
            operand  = regs[dec.src];
            carry_in = dec.with_c && regs[SEL_F][4];
          end
          OPK_MEM: st_d = ST_MEM;
          OPK_IMM: st_d = ST_IMM;
          default: ill_hit = 1'b1;
        endcase
      end
      ST_IMM: if (accept) begin
        wb_fire = 1'b1;
        st_d    = ST_IDLE;
      end
      ST_MEM: begin
        operand = mem_rdata;
        if (mem_rvalid) begin
          wb_fire = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= wb_fire;
      ill_q  <= ill_hit;
    end
  end

  assign mem_req   = (st_q == ST_MEM);
  assign mem_addr  = {regs[SEL_H], regs[SEL_L]};
  assign acc_o     = regs[SEL_A];
  assign flag_o    = regs[SEL_F];
  assign done_o    = done_q;
  assign illegal_o = ill_q;

  AST_SUB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> !flag_o[6]); // R8
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> (flag_o[7] == (acc_o == 8'h00))); // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> mem_req); // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_hit && !ld_en) |=> ($stable(acc_o) && $stable(flag_o))); // R12
  AST_ILLEGAL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !done_o); // R12
endmodule

// File: tb/accadd_unit_tb.sv
`timescale 1ns/1ps
module accadd_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = '0;
  logic [7:0]  ld_data = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  acc_o, flag_o;
  logic        done_o, illegal_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  accadd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .acc_o(acc_o), .flag_o(flag_o),
    .done_o(done_o), .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input int sel, input int data);
    ld_en = 1'b1; ld_sel = 3'(sel); ld_data = 8'(data);
    tick();
    ld_en = 1'b0;
  endtask

  task automatic send(input int b);
    in_valid = 1'b1; in_byte = 8'(b);
    tick();
    in_valid = 1'b0;
  endtask

  // Reference: {result, flag byte}
  function automatic logic [15:0] ref_add(input int a, input int b, input int ci);
    int s, r;
    logic z, h, c;
    s = a + b + ci;
    r = s % 256;
    z = (r == 0);
    h = ((a % 16) + (b % 16) + ci) > 15;
    c = s > 255;
    return {8'(r), z, 1'b0, h, c, 4'h0};
  endfunction

  task automatic chk_result(input logic [15:0] e, input string rq);
    chk(acc_o == e[15:8], rq, acc_o, e[15:8]);
    chk(flag_o[7] == e[7], "R7", flag_o[7], e[7]);
    chk(flag_o[6] == 1'b0, "R8", flag_o[6], 0);
    chk(flag_o[5] == e[5], "R9", flag_o[5], e[5]);
    chk(flag_o[4] == e[4], "R10", flag_o[4], e[4]);
    chk(flag_o[3:0] == 4'h0, "R11", flag_o[3:0], 0);
    chk(done_o == 1'b1, rq, done_o, 1);
  endtask

  function automatic bit is_legal(input int op);
    return (op >= 8'h80 && op <= 8'h85) || (op >= 8'h88 && op <= 8'h8D) ||
           op == 8'h86 || op == 8'hC6;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(acc_o == 0, "R1", acc_o, 0);
    chk(flag_o == 0, "R1", flag_o, 0);
    chk(in_ready == 1, "R1", in_ready, 1);
    chk(mem_req == 0, "R1", mem_req, 0);
    chk(done_o == 0 && illegal_o == 0, "R1", {done_o, illegal_o}, 0);
    chk(mem_addr == 0, "R1", mem_addr, 0);

    // R2 load port: H=4, L=5 seen on mem_addr, A=7 on acc_o, F=6 masked
    load(4, 8'hA5); load(5, 8'h3C);
    chk(mem_addr == 16'hA53C, "R2", mem_addr, 16'hA53C);
    load(7, 8'h66);
    chk(acc_o == 8'h66, "R2", acc_o, 8'h66);
    load(6, 8'hFF);
    chk(flag_o == 8'hF0, "R11", flag_o, 8'hF0);

    // R3 / R4 sweep over accumulator, operand, carry, opcode group
    for (int a = 0; a < 256; a += 5) begin
      for (int b = 0; b < 256; b += 15) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int adc = 0; adc < 2; adc++) begin
            int src;
            src = (a / 5 + b / 15 + ci) % 6;
            load(7, a);
            load(src, b);
            load(6, {1'(a % 2 == 0), 1'b1, 1'(a % 2 == 1), 1'(ci), 4'hF});
            send((adc ? 8'h88 : 8'h80) + src);
            e = ref_add(a, b, adc ? ci : 0);
            chk_result(e, adc ? "R4" : "R3");
          end
        end
      end
    end

    // R5 immediate form
    for (int a = 0; a < 256; a += 3) begin
      for (int n = 0; n < 256; n += 11) begin
        load(7, a);
        load(6, 8'hF0);
        send(8'hC6);
        chk(in_ready == 1 && done_o == 0 && acc_o == 8'(a), "R5",
            {in_ready, done_o, acc_o}, {2'b10, 8'(a)});
        send(n);
        e = ref_add(a, n, 0);
        chk_result(e, "R5");
      end
    end
    // R5 boundary: 0xFF + 0x01 => 0x00 with Z, H, C
    load(7, 8'hFF); send(8'hC6); send(8'h01);
    chk(acc_o == 0 && flag_o == 8'hB0, "R5", {acc_o, flag_o}, 16'h00B0);

    // R6 memory form, with stray input bytes during the wait
    for (int k = 0; k < 16; k++) begin
      int hv, lv, av, dv;
      hv = (k * 37 + 5) % 256; lv = (k * 91 + 17) % 256;
      av = (k * 53) % 256;     dv = (k * 29 + 200) % 256;
      load(4, hv); load(5, lv); load(7, av); load(6, 8'hD0);
      send(8'h86);
      chk(mem_req == 1 && in_ready == 0, "R6", {mem_req, in_ready}, 2'b10);
      chk(mem_addr == {8'(hv), 8'(lv)}, "R6", mem_addr, {8'(hv), 8'(lv)});
      in_valid = 1'b1; in_byte = 8'h80;
      tick(); tick();
      in_valid = 1'b0;
      chk(mem_req == 1 && acc_o == 8'(av) && done_o == 0, "R6",
          {mem_req, done_o, acc_o}, {2'b10, 8'(av)});
      mem_rdata = 8'(dv); mem_rvalid = 1'b1;
      tick();
      mem_rvalid = 1'b0;
      chk(mem_req == 0 && in_ready == 1, "R6", {mem_req, in_ready}, 2'b01);
      e = ref_add(av, dv, 0);
      chk_result(e, "R6");
    end

    // R7 carry-in defeats zero; R10 double full carry
    load(7, 0); load(1, 0); load(6, 8'h10); send(8'h89);
    chk(acc_o == 1 && flag_o == 8'h00, "R7", {acc_o, flag_o}, 16'h0100);
    load(7, 8'hFF); load(2, 8'hFF); load(6, 8'h10); send(8'h8A);
    chk(acc_o == 8'hFF && flag_o == 8'h30, "R10", {acc_o, flag_o}, 16'hFF30);

    // R12 every unsupported opcode
    load(7, 8'h3C); load(6, 8'hA0);
    for (int op = 0; op < 256; op++) begin
      if (!is_legal(op)) begin
        send(op);
        chk(illegal_o == 1 && done_o == 0, "R12", {illegal_o, done_o}, 2'b10);
        chk(acc_o == 8'h3C && flag_o == 8'hA0 && in_ready == 1, "R12",
            {acc_o, flag_o}, 16'h3CA0);
      end
    end
    load(0, 8'h01); send(8'h80);
    chk(acc_o == 8'h3D && illegal_o == 0, "R12", acc_o, 8'h3D);

    // R13 load to A together with write-back: write-back wins
    load(7, 8'h10); load(1, 8'h22); load(6, 8'h00);
    in_valid = 1'b1; in_byte = 8'h81;
    ld_en = 1'b1; ld_sel = 3'd7; ld_data = 8'h99;
    tick();
    in_valid = 1'b0; ld_en = 1'b0;
    chk(acc_o == 8'h32, "R13", acc_o, 8'h32);
    // load to F together with write-back: write-back wins
    load(7, 8'h0F); load(1, 8'h01);
    in_valid = 1'b1; in_byte = 8'h81;
    ld_en = 1'b1; ld_sel = 3'd6; ld_data = 8'hF0;
    tick();
    in_valid = 1'b0; ld_en = 1'b0;
    chk(acc_o == 8'h10 && flag_o == 8'h20, "R13", {acc_o, flag_o}, 16'h1020);
    // load to the source register: old value used, new value kept
    load(7, 8'h05); load(0, 8'h07);
    in_valid = 1'b1; in_byte = 8'h80;
    ld_en = 1'b1; ld_sel = 3'd0; ld_data = 8'h40;
    tick();
    in_valid = 1'b0; ld_en = 1'b0;
    chk(acc_o == 8'h0C, "R13", acc_o, 8'h0C);
    load(7, 8'h00); load(6, 8'h00); send(8'h80);
    chk(acc_o == 8'h40, "R13", acc_o, 8'h40);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule